// File: doc/BRIEF.md
# Debug Byte-Stream Bypass Unlock

This block sits behind the receiver of a serial debug port and inspects every byte that arrives. When it sees a three-byte write command (a sync byte, a register-write command byte, then one data byte), it loads the data byte into an 8-bit test-mode register. Bit 2 of that register drives a flag that hands the flash array over to direct pin control, bypassing the flash controller.

The receiver's bit timing and its rate measurement are not part of this block. The block sees only a strobe that marks a valid byte, plus the byte itself. Any byte that breaks the expected order sends the detector back to its start. The only exception is a sync byte, which always begins a new sequence. Bypass stays on until a reset, or until a later write command stores a value with bit 2 clear.

Top module: `dbg_bypass_unlock`

## Requirements
- R1: A synchronous active-high reset clears the test-mode register to 00h. It also returns the detector to idle, so a command byte F0h followed by a data byte right after reset writes nothing.
- R2: The byte order 80h (sync), then F0h (write command), then D stores D into the test-mode register. The new value is visible on the clock edge that samples D.
- R3: The bypass flag equals bit 2 of the test-mode register at all times. Writing 04h sets the flag.
- R4: The byte that follows the command is always taken as data and written, whatever its value, including 80h and F0h. The detector then returns to idle.
- R5: After a sync byte, any byte other than F0h or 80h returns the detector to idle and writes nothing.
- R6: A sync byte (80h) received while the detector waits for the command restarts the sequence. So 80h, 80h, F0h, D writes D.
- R7: Cycles without the byte strobe neither advance nor reset the detector. Gaps between the bytes of a sequence are allowed.
- R8: A later complete write whose data has bit 2 clear turns the bypass flag off.
- R9: A command byte or data byte that does not follow the full preceding order leaves the register unchanged.
- R10: The test-mode register changes only on the edge that accepts a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Strobe: rx_byte holds a received byte this cycle |
| rx_byte | input | 8 | Received byte |
| tm_reg | output | 8 | Test-mode register contents |
| bypass_en | output | 1 | Flash controller bypass enable (register bit 2) |

## Verification
A wrong detector state shows at the ports only when the next data byte arrives. The register then takes a value it should not take, or misses one it should. Because of this, the bench ends every probe sequence with a data byte and reads `tm_reg` and `bypass_en` one edge later. The second-position byte is swept over all 256 values, and so is the data value, so a wrong comparison constant or a wrong reject path changes a visible value within one byte of the fault.

// File: rtl/dbg_unlock_pkg.sv
package dbg_unlock_pkg;
    localparam int BYTE_W     = 8;
    localparam int BYPASS_BIT = 2;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h80;
    localparam logic [BYTE_W-1:0] WR_CMD    = 8'hF0;
    localparam logic [BYTE_W-1:0] TM_RESET  = 8'h00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_CMD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [BYTE_W-1:0] data;
    } tm_write_t;

    function automatic seq_state_e next_state(input seq_state_e cur, input logic [BYTE_W-1:0] b);
        seq_state_e nxt;
        case (cur)
            ST_IDLE: nxt = (b == SYNC_BYTE) ? ST_SYNC : ST_IDLE;
            ST_SYNC: begin
                if (b == WR_CMD)         nxt = ST_CMD;
                else if (b == SYNC_BYTE) nxt = ST_SYNC;
                else                     nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/dbg_seq_detect.sv
module dbg_seq_detect
    import dbg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output tm_write_t         wr_req
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else if (rx_valid)
            state <= next_state(state, rx_byte);
    end

    always_comb begin
        wr_req.wr   = rx_valid && (state == ST_CMD);
        wr_req.data = rx_byte;
    end

    assert_data_done_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state == ST_CMD) |=> (state == ST_IDLE));
    assert_reject_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && state == ST_SYNC && rx_byte != WR_CMD && rx_byte != SYNC_BYTE) |=> (state == ST_IDLE));
    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_byte == SYNC_BYTE && state != ST_CMD) |=> (state == ST_SYNC));
    assert_gap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(state));
endmodule

// File: rtl/dbg_tm_reg.sv
module dbg_tm_reg
    import dbg_unlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tm_write_t         wr_req,
    output logic [BYTE_W-1:0] tm_q
);
    always_ff @(posedge clk) begin
        if (rst)
            tm_q <= TM_RESET;
        else if (wr_req.wr)
            tm_q <= wr_req.data;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_req.wr |=> (tm_q == $past(wr_req.data)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_req.wr |=> $stable(tm_q));
endmodule

// File: rtl/dbg_bypass_unlock.sv
module dbg_bypass_unlock
    import dbg_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic [7:0] tm_reg,
    output logic       bypass_en
);
    tm_write_t wr_req;

    dbg_seq_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .wr_req  (wr_req)
    );

    dbg_tm_reg u_tm (
        .clk   (clk),
        .rst   (rst),
        .wr_req(wr_req),
        .tm_q  (tm_reg)
    );

    assign bypass_en = tm_reg[BYPASS_BIT];

    assert_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass_en) |-> $past(wr_req.wr));
    assert_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_en) |-> $past(wr_req.wr && wr_req.data[BYPASS_BIT]));
endmodule

// File: tb/dbg_bypass_unlock_bench.sv
module dbg_bypass_unlock_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tm_reg;
    logic       bypass_en;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_bypass_unlock u_dbg_bypass_unlock (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tm_reg(tm_reg), .bypass_en(bypass_en)
    );

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write_tm(input logic [7:0] d);
        send(8'h80); send(8'hF0); send(d);
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: reset value
        chk("R1", tm_reg, 8'h00);
        chk("R1", {7'd0, bypass_en}, 8'h00);
        // R1/R9: command without sync after reset
        send(8'hF0); send(8'h04);
        chk("R1", tm_reg, 8'h00);
        // R2/R3/R4: sweep all data values
        for (int d = 0; d < 256; d++) begin
            write_tm(d[7:0]);
            chk("R2", tm_reg, d[7:0]);
            chk("R3", {7'd0, bypass_en}, {7'd0, d[2]});
        end
        // R5/R6: sweep second-position byte, probe with 04h
        for (int x = 0; x < 256; x++) begin
            write_tm(8'h00);
            send(8'h80); send(x[7:0]); send(8'h04);
            chk("R5", tm_reg, (x == 8'hF0) ? 8'h04 : 8'h00);
        end
        // R6: repeated sync restarts
        send(8'h80); send(8'h80); send(8'h80); send(8'hF0); send(8'h24);
        chk("R6", tm_reg, 8'h24);
        // R4: data equal to sync, detector back to idle afterwards
        write_tm(8'h80);
        chk("R4", tm_reg, 8'h80);
        send(8'hF0); send(8'h11);
        chk("R4", tm_reg, 8'h80);
        write_tm(8'hF0);
        chk("R4", tm_reg, 8'hF0);
        send(8'h33);
        chk("R10", tm_reg, 8'hF0);
        // R7: gaps inside the sequence
        send(8'h80); idle(5); send(8'hF0); idle(7); send(8'h0C);
        chk("R7", tm_reg, 8'h0C);
        chk("R7", {7'd0, bypass_en}, 8'h01);
        // R8: clear bypass with later write
        write_tm(8'hFB);
        chk("R8", tm_reg, 8'hFB);
        chk("R8", {7'd0, bypass_en}, 8'h00);
        // R9: data with no command, command with no sync
        send(8'h04);
        chk("R9", tm_reg, 8'hFB);
        send(8'h55); send(8'hF0); send(8'h04);
        chk("R9", tm_reg, 8'hFB);
        // R10: register stable across idle cycles and partial sequences
        send(8'h80); idle(4);
        chk("R10", tm_reg, 8'hFB);
        send(8'hF0); idle(4);
        chk("R10", tm_reg, 8'hFB);
        send(8'h04);
        chk("R10", tm_reg, 8'h04);
        // R1: reset mid-sequence clears register and state
        send(8'h80); send(8'hF0);
        do_reset();
        chk("R1", tm_reg, 8'h00);
        send(8'h04);
        chk("R1", tm_reg, 8'h00);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule